// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Parallel Load

This block is a small binary counter driven by two separate active-low count strobes instead of a clock and a direction pin. One strobe moves the count up, the other moves it down. The two are ANDed into one combined strobe. When the combined strobe falls, the block notes which strobe pulled it low. When it rises again, the block takes one step in that direction. A level-sensitive parallel load and an overriding clear complete the function.

Every input is oversampled by a fast system clock through multi-stage synchronizers. Strobe edges are found by comparing each synchronized sample with the one before it. A single register process owns the count. No gated clocks and no dual-edge storage are used, so the block synthesizes on any standard flop library. Two active-low flags mark the terminal count for the up direction and for the down direction, which allows counters to be cascaded.

Top module: `updn_strobe_counter`

## Requirements
- R1: After the system reset `rst_n` is asserted, `count` is 0 and both `carry_n` and `borrow_n` are 1.
- R2: A low pulse on `up_n` while `dn_n` stays high adds one to `count`. The step happens when `up_n` returns high. The count does not change while `up_n` is held low, and it does not change while no strobe, load or clear is active.
- R3: A low pulse on `dn_n` while `up_n` stays high subtracts one from `count`. The step happens when `dn_n` returns high.
- R4: The count wraps modulo 2^CNT_W. An up step from 15 gives 0, and a down step from 0 gives 15 (CNT_W = 4).
- R5: While `load_n` is low, `count` follows `din`, including changes of `din` made during the load.
- R6: A strobe pulse that completes while `load_n` is low causes no step. After the load is released, `count` still equals the loaded value.
- R7: While `clr` is high, `count` is 0, even if `load_n` is low at the same time.
- R8: If `up_n` and `dn_n` are both low at any time during one low period of the combined strobe, no step is taken when that strobe rises.
- R9: `carry_n` is 0 exactly when `count` is all ones and `up_n` is low. `borrow_n` is 0 exactly when `count` is 0 and `dn_n` is low. Otherwise each flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| up_n | input | 1 | Active-low up-count strobe, idle high |
| dn_n | input | 1 | Active-low down-count strobe, idle high |
| clr | input | 1 | Active-high clear, highest priority |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| din | input | CNT_W | Parallel load data |
| count | output | CNT_W | Current count value |
| carry_n | output | 1 | Active-low up terminal-count flag |
| borrow_n | output | 1 | Active-low down terminal-count flag |

## Verification
Every input goes through SYNC_STAGES flops before any logic sees it.

**Count latency.** A strobe return, a load level or a clear reaches `count` on the third system clock edge after the input changes.

**Flag latency.** The flags depend on the synchronized strobe levels and the registered count. They settle one edge earlier than `count`.

**Sampling.** The bench holds each input level for four clock edges before sampling at the following falling edge. Every result is therefore settled when it is read. For R2, the bench also samples while a strobe is held low, to show that the count has not yet moved.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DN   = 2'd2
   } step_dir_e;

   function automatic step_dir_e pick_dir(input logic up_lvl, input logic dn_lvl);
      if (!up_lvl && dn_lvl)
         return DIR_UP;
      else if (up_lvl && !dn_lvl)
         return DIR_DN;
      else
         return DIR_NONE;
   endfunction

endpackage

// File: rtl/updn_cnt_sync.sv
module updn_cnt_sync #(
   parameter int unsigned     W       = 8,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("updn_cnt_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("updn_cnt_sync: W must be at least 1");
      end

      for (genvar b = 0; b < W; b++) begin : g_bit
         logic [STAGES-1:0] chain;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain <= {STAGES{RST_VAL[b]}};
            else
               chain <= {chain[STAGES-2:0], d[b]};
         end

         assign q[b] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/updn_cnt_strobe.sv
module updn_cnt_strobe
   import updn_cnt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic up_s,
   input  logic dn_s,
   output logic step_up,
   output logic step_dn
);

   logic      strb;
   logic      strb_q;
   logic      strb_fall;
   logic      strb_rise;
   step_dir_e dir_q;

   // combined strobe: low whenever either count input is low
   assign strb      = up_s & dn_s;
   assign strb_fall = strb_q & ~strb;
   assign strb_rise = ~strb_q & strb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b1;
         dir_q  <= DIR_NONE;
      end else begin
         strb_q <= strb;
         if (strb_fall)
            dir_q <= pick_dir(up_s, dn_s);
         else if (!up_s && !dn_s)
            dir_q <= DIR_NONE;   // both low spoils the pending step
      end
   end

   assign step_up = strb_rise && (dir_q == DIR_UP);
   assign step_dn = strb_rise && (dir_q == DIR_DN);

endmodule

// File: rtl/updn_cnt_reg.sv
module updn_cnt_reg #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] din,
   input  logic             step_up,
   input  logic             step_dn,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // sole writer of the count; clear > load > step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (load)
         count <= din;
      else if (step_up)
         count <= count + ONE;
      else if (step_dn)
         count <= count - ONE;
   end

endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter #(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_n,
   input  logic             dn_n,
   input  logic             clr,
   input  logic             load_n,
   input  logic [CNT_W-1:0] din,
   output logic [CNT_W-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);

   localparam int unsigned      SYN_W   = CNT_W + 4;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   // sync vector layout: {din, load_n, clr, dn_n, up_n}; idle levels on reset
   localparam logic [SYN_W-1:0] SYN_RST = {{CNT_W{1'b0}}, 1'b1, 1'b0, 1'b1, 1'b1};

   generate
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("updn_strobe_counter: CNT_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("updn_strobe_counter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYN_W-1:0] raw_vec;
   logic [SYN_W-1:0] syn_vec;
   logic             up_s;
   logic             dn_s;
   logic             clr_s;
   logic             load_s;
   logic [CNT_W-1:0] din_s;
   logic             step_up;
   logic             step_dn;

   assign raw_vec = {din, load_n, clr, dn_n, up_n};

   updn_cnt_sync #(
      .W       (SYN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_vec),
      .q     (syn_vec)
   );

   assign up_s   = syn_vec[0];
   assign dn_s   = syn_vec[1];
   assign clr_s  = syn_vec[2];
   assign load_s = ~syn_vec[3];
   assign din_s  = syn_vec[SYN_W-1:4];

   updn_cnt_strobe u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .up_s    (up_s),
      .dn_s    (dn_s),
      .step_up (step_up),
      .step_dn (step_dn)
   );

   updn_cnt_reg #(
      .CNT_W (CNT_W)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_s),
      .load    (load_s),
      .din     (din_s),
      .step_up (step_up),
      .step_dn (step_dn),
      .count   (count)
   );

   assign carry_n  = ~((count == CNT_MAX) & ~up_s);
   assign borrow_n = ~((count == '0) & ~dn_s);

endmodule

// File: rtl/updn_strobe_counter_chk.sv
module updn_strobe_counter_chk #(
   parameter int unsigned CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic             carry_n,
   input logic             borrow_n,
   input logic             up_s,
   input logic             dn_s,
   input logic             clr_s,
   input logic             load_s,
   input logic [CNT_W-1:0] din_s,
   input logic             step_up,
   input logic             step_dn
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !clr_s && !load_s) |=> (count == $past(count) + ONE));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_up && !step_dn && !clr_s && !load_s) |=> $stable(count));

   assert_step_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dn && !clr_s && !load_s) |=> (count == $past(count) - ONE));

   assert_load_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_s && !clr_s) |=> (count == $past(din_s)));

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_s |=> (count == '0));

   assert_both_low_no_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_s && !dn_s) |=> (!step_up && !step_dn));

   assert_carry_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |-> (count == MAXV));

   assert_borrow_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n |-> (count == '0));

endmodule

bind updn_strobe_counter updn_strobe_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .count    (count),
   .carry_n  (carry_n),
   .borrow_n (borrow_n),
   .up_s     (up_s),
   .dn_s     (dn_s),
   .clr_s    (clr_s),
   .load_s   (load_s),
   .din_s    (din_s),
   .step_up  (step_up),
   .step_dn  (step_dn)
);

// File: tb/test_updn_strobe_counter.sv
module test_updn_strobe_counter;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;

   localparam logic [2:0] OP_UP   = 3'd0;
   localparam logic [2:0] OP_DN   = 3'd1;
   localparam logic [2:0] OP_LOAD = 3'd2;
   localparam logic [2:0] OP_CLR  = 3'd3;
   localparam logic [2:0] OP_BOTH = 3'd4;

   // {op, din, expected count}
   localparam int NVEC = 12;
   localparam logic [10:0] VEC [NVEC] = '{
      {OP_LOAD, 4'd9,  4'd9},
      {OP_UP,   4'd0,  4'd10},
      {OP_UP,   4'd0,  4'd11},
      {OP_DN,   4'd0,  4'd10},
      {OP_LOAD, 4'd15, 4'd15},
      {OP_UP,   4'd0,  4'd0},
      {OP_DN,   4'd0,  4'd15},
      {OP_BOTH, 4'd0,  4'd15},
      {OP_CLR,  4'd0,  4'd0},
      {OP_DN,   4'd0,  4'd15},
      {OP_LOAD, 4'd3,  4'd3},
      {OP_DN,   4'd0,  4'd2}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         up_n = 1'b1;
   logic         dn_n = 1'b1;
   logic         clr = 1'b0;
   logic         load_n = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] count;
   logic         carry_n;
   logic         borrow_n;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   updn_strobe_counter #(.CNT_W(W), .SYNC_STAGES(2)) i_updn_strobe_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_n     (up_n),
      .dn_n     (dn_n),
      .clr      (clr),
      .load_n   (load_n),
      .din      (din),
      .count    (count),
      .carry_n  (carry_n),
      .borrow_n (borrow_n)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic string op_req(input logic [2:0] op);
      case (op)
         OP_UP:   return "R2/R4 up step";
         OP_DN:   return "R3/R4 down step";
         OP_LOAD: return "R5 load";
         OP_CLR:  return "R7 clear";
         default: return "R8 both low";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 count", count, 0);
      check("R1 carry_n", carry_n, 1);
      check("R1 borrow_n", borrow_n, 1);
      rst_n = 1'b1;
      settle();
      check("R1 count after release", count, 0);

      // vector table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [2:0] op;
         op = VEC[i][10:8];
         case (op)
            OP_UP: begin
               up_n = 1'b0; settle(); up_n = 1'b1; settle();
            end
            OP_DN: begin
               dn_n = 1'b0; settle(); dn_n = 1'b1; settle();
            end
            OP_LOAD: begin
               din = VEC[i][7:4]; load_n = 1'b0; settle(); load_n = 1'b1; settle();
            end
            OP_CLR: begin
               clr = 1'b1; settle(); clr = 1'b0; settle();
            end
            default: begin
               up_n = 1'b0; settle(); dn_n = 1'b0; settle();
               up_n = 1'b1; settle(); dn_n = 1'b1; settle();
            end
         endcase
         check(op_req(op), count, int'(VEC[i][3:0]));
         check("R9 idle flags", {carry_n, borrow_n}, 3);
      end

      // R5: count follows din while the load is held
      din = 4'd5; load_n = 1'b0; settle();
      check("R5 follow 5", count, 5);
      din = 4'd12; settle();
      check("R5 follow 12", count, 12);
      // R6: strobe during load causes no step
      up_n = 1'b0; settle(); up_n = 1'b1; settle();
      check("R6 up during load", count, 12);
      load_n = 1'b1; settle();
      check("R6 after load release", count, 12);

      // R7: clear overrides load
      din = 4'd7; load_n = 1'b0; clr = 1'b1; settle();
      check("R7 clear over load", count, 0);
      clr = 1'b0; settle();
      check("R5 load after clear", count, 7);
      load_n = 1'b1; settle();

      // R2: no step while up held low; step on return high
      up_n = 1'b0; settle();
      check("R2 hold while low", count, 7);
      check("R9 carry_n not at max", carry_n, 1);
      up_n = 1'b1; settle();
      check("R2 step on rise", count, 8);

      // R9: carry flag at all ones with up low
      din = 4'd15; load_n = 1'b0; settle(); load_n = 1'b1; settle();
      up_n = 1'b0; settle();
      check("R9 carry_n low", carry_n, 0);
      check("R9 borrow_n high", borrow_n, 1);
      up_n = 1'b1; settle();
      check("R4 wrap up", count, 0);
      check("R9 carry_n released", carry_n, 1);
      dn_n = 1'b0; settle();
      check("R9 borrow_n low", borrow_n, 0);
      check("R3 hold while low", count, 0);
      dn_n = 1'b1; settle();
      check("R4 wrap down", count, 15);
      check("R9 borrow_n released", borrow_n, 1);

      // R8: both low, opposite order
      dn_n = 1'b0; settle(); up_n = 1'b0; settle();
      dn_n = 1'b1; settle(); up_n = 1'b1; settle();
      check("R8 both low reversed", count, 15);

      // R1: reset in mid-run
      rst_n = 1'b0; settle();
      check("R1 mid-run reset", count, 0);
      rst_n = 1'b1; settle();
      check("R1 count after second release", count, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule